// File: doc/BRIEF.md
# Sample Stream 1:2 Demultiplexer

This block takes one 6-bit converted sample on each rising edge of the conversion clock. It carries each sample through a short chain of register stages, then splits the stream across two output ports. The two ports update together once every two conversion clocks. Port 1 always receives the older sample of each pair and port 2 the sample one conversion period newer, so a downstream consumer running at half rate sees the full stream.

The half-rate update is produced inside the block by a phase toggle, so everything runs in the conversion clock domain. A strobe output marks the cycle right after each port update. A polarity control complements every output bit as the ports load. A valid flag rises with the first update that carries only samples taken after reset. With the input scaled as by the converter, code 0 is the top of the input range and code 63 is the bottom.

Top module: `dmx_sample_split`

## Requirements
- R1: A synchronous active-high reset clears both ports to 000000 and drives strobe and valid low. The polarity control has no effect while reset is held.
- R2: Counting the first rising edge with reset low as edge 1, the ports update on edges 1, 3, 5 and so on. The strobe is high for exactly the one clock cycle that follows each update edge and is low otherwise.
- R3: With the polarity control low, port 1 after update edge e holds the sample captured on edge e-4, bit for bit (bit 0 LSB, bit 5 MSB). Samples captured on edge 0 or earlier read as 000000.
- R4: Port 2 after update edge e holds the sample captured on edge e-3, one conversion period newer than port 1.
- R5: Between update edges both ports hold their values, whatever the sample input does.
- R6: When the polarity control is high at an update edge, every bit loaded on both ports is complemented: code 0 appears as 111111 and code 63 as 000000.
- R7: The polarity control is sampled only at update edges. A change between updates does not alter the ports until the next update.
- R8: Valid stays low until update edge 5, the first update where both ports carry samples taken after reset. It then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, all logic on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 6 | Converted sample, captured every clock |
| invert_i | input | 1 | Output polarity control, active high |
| port1_o | output | 6 | Older sample of each pair |
| port2_o | output | 6 | Newer sample of each pair |
| strobe_o | output | 1 | High for the cycle after each port update |
| valid_o | output | 1 | Ports carry post-reset samples |

## Verification
A phase toggle that slips by one clock makes the ports update on even edges. The pairs then shift, so port 1 shows the sample that should be on port 2, and the strobe check at the first expected update (edge 1) already fails. A pipeline stage that holds or skips a value changes the latency. The ramp shows this within five clocks as a sample value off by one on either port. Inversion applied at the wrong moment shows up as complemented codes on steps where the randomly toggled polarity input is low, or plain codes where it is high.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;

   // Phase of the half-rate toggle: ports load while in PH_LOAD.
   typedef enum logic {
      PH_LOAD = 1'b0,
      PH_IDLE = 1'b1
   } dmx_phase_e;

   // First update edge at which port 1 carries a post-reset sample.
   function automatic int fill_edge(input int depth);
      return ((depth % 2) == 0) ? depth + 1 : depth + 2;
   endfunction

endpackage

// File: rtl/dmx_pipe.sv
`timescale 1ns/1ps
module dmx_pipe #(
   parameter int W     = 6,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] older_o,
   output logic [W-1:0] newer_o
);

   logic [W-1:0] stg [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
      end else begin
         stg[0] <= din;
         for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
      end
   end

   assign older_o = stg[DEPTH-1];
   assign newer_o = stg[DEPTH-2];

   generate
      if (W < 1) begin : g_bad_w
         $error("dmx_pipe: W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("dmx_pipe: DEPTH must be at least 2");
      end
      for (genvar k = 1; k < DEPTH; k++) begin : g_chk
         // R3 R4: every stage takes the previous stage's value one clock later
         p_stage_shift_r3: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> stg[k] == $past(stg[k-1]));
      end
   endgenerate

endmodule

// File: rtl/dmx_phase.sv
`timescale 1ns/1ps
module dmx_phase
   import dmx_pkg::*;
#(
   parameter int FILL_LOADS = 3
) (
   input  logic clk,
   input  logic rst,
   output logic ld_o,
   output logic strobe_o,
   output logic valid_o
);

   localparam int CW = $clog2(FILL_LOADS + 1);

   dmx_phase_e    ph;
   logic          strobe_q;
   logic          valid_q;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) ph <= PH_LOAD;
      else     ph <= (ph == PH_LOAD) ? PH_IDLE : PH_LOAD;
   end

   assign ld_o = (ph == PH_LOAD) && !rst;

   always_ff @(posedge clk) begin
      if (rst) strobe_q <= 1'b0;
      else     strobe_q <= ld_o;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         valid_q <= 1'b0;
      end else if (ld_o && !valid_q) begin
         if (cnt == CW'(FILL_LOADS - 1)) valid_q <= 1'b1;
         else                            cnt     <= cnt + 1'b1;
      end
   end

   assign strobe_o = strobe_q;
   assign valid_o  = valid_q;

   generate
      if (FILL_LOADS < 1) begin : g_bad_fill
         $error("dmx_phase: FILL_LOADS must be at least 1");
      end
   endgenerate

   // R2: a strobe cycle is always followed by a quiet cycle
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
      strobe_q |=> !strobe_q);
   // R2: a quiet cycle is always followed by a strobe cycle
   p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
      !strobe_q |=> strobe_q);
   // R8: valid never drops without reset
   p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      valid_q |=> valid_q);
   // R8: valid rises only together with an update
   p_valid_on_update_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_q) |-> strobe_q);

endmodule

// File: rtl/dmx_outreg.sv
`timescale 1ns/1ps
module dmx_outreg #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld_i,
   input  logic         inv_i,
   input  logic [W-1:0] older_i,
   input  logic [W-1:0] newer_i,
   output logic [W-1:0] p1_o,
   output logic [W-1:0] p2_o
);

   logic [W-1:0] mask;
   logic [W-1:0] p1_q, p2_q;

   generate
      for (genvar b = 0; b < W; b++) begin : g_mask
         assign mask[b] = inv_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         p1_q <= '0;
         p2_q <= '0;
      end else if (ld_i) begin
         p1_q <= older_i ^ mask;
         p2_q <= newer_i ^ mask;
      end
   end

   assign p1_o = p1_q;
   assign p2_o = p2_q;

   // R5 R7: without a load both ports keep their value
   p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
      !ld_i |=> $stable(p1_q) && $stable(p2_q));
   // R6: with the polarity control high the loaded port is the complement
   p_complement_r6: assert property (@(posedge clk) disable iff (rst)
      (ld_i && inv_i) |=> (p1_q ^ $past(older_i)) == {W{1'b1}});

endmodule

// File: rtl/dmx_sample_split.sv
`timescale 1ns/1ps
module dmx_sample_split
   import dmx_pkg::*;
#(
   parameter int SAMPLE_W   = 6,
   parameter int PIPE_DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                invert_i,
   output logic [SAMPLE_W-1:0] port1_o,
   output logic [SAMPLE_W-1:0] port2_o,
   output logic                strobe_o,
   output logic                valid_o
);

   localparam int FILL_EDGE  = fill_edge(PIPE_DEPTH);
   localparam int FILL_LOADS = (FILL_EDGE + 1) / 2;

   logic [SAMPLE_W-1:0] older, newer;
   logic                ld;

   dmx_pipe #(.W(SAMPLE_W), .DEPTH(PIPE_DEPTH)) u_pipe (
      .clk     (clk),
      .rst     (rst),
      .din     (sample_i),
      .older_o (older),
      .newer_o (newer)
   );

   dmx_phase #(.FILL_LOADS(FILL_LOADS)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .ld_o     (ld),
      .strobe_o (strobe_o),
      .valid_o  (valid_o)
   );

   dmx_outreg #(.W(SAMPLE_W)) u_out (
      .clk     (clk),
      .rst     (rst),
      .ld_i    (ld),
      .inv_i   (invert_i),
      .older_i (older),
      .newer_i (newer),
      .p1_o    (port1_o),
      .p2_o    (port2_o)
   );

   // R1: the cycle after a reset edge shows cleared ports and flags
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (port1_o == '0) && (port2_o == '0) && !strobe_o && !valid_o);
   // R2 R5: port contents move only in a strobe cycle
   p_change_with_strobe_r2: assert property (@(posedge clk) disable iff (rst)
      !strobe_o |-> $stable(port1_o) || $past(rst));

endmodule

// File: tb/tb_dmx_sample_split.sv
`timescale 1ns/1ps
module tb_dmx_sample_split;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] sample_i = '0;
   logic       invert_i = 1'b0;
   logic [5:0] port1_o, port2_o;
   logic       strobe_o, valid_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   int         edge_n = 0;
   logic [5:0] hist [0:4095];
   logic [5:0] exp1, exp2;

   always #2.5 clk = ~clk;

   dmx_sample_split dut (
      .clk      (clk),
      .rst      (rst),
      .sample_i (sample_i),
      .invert_i (invert_i),
      .port1_o  (port1_o),
      .port2_o  (port2_o),
      .strobe_o (strobe_o),
      .valid_o  (valid_o)
   );

   task automatic chk(input string req, input int act, input int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp_v, edge_n);
      end
   endtask

   function automatic logic [5:0] code_at(input int e);
      return (e >= 1) ? hist[e] : 6'd0;
   endfunction

   // one conversion clock: drive, capture edge, update the model, check
   task automatic step(input logic [5:0] s, input logic iv);
      sample_i = s;
      invert_i = iv;
      @(posedge clk);
      edge_n++;
      hist[edge_n] = s;
      if (edge_n % 2 == 1) begin
         exp1 = code_at(edge_n - 4) ^ {6{iv}};
         exp2 = code_at(edge_n - 3) ^ {6{iv}};
      end
      @(negedge clk);
      chk(iv ? "R6 port1" : "R3 port1", port1_o, exp1);
      chk(iv ? "R6 port2" : "R4 port2", port2_o, exp2);
      chk("R2 strobe", strobe_o, (edge_n % 2 == 1) ? 1 : 0);
      chk("R8 valid", valid_o, (edge_n >= 5) ? 1 : 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst      = 1'b1;
      invert_i = 1'b1;
      sample_i = 6'h2A;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 port1", port1_o, 0);
      chk("R1 port2", port2_o, 0);
      chk("R1 strobe", strobe_o, 0);
      chk("R1 valid", valid_o, 0);
      rst    = 1'b0;
      edge_n = 0;
      exp1   = '0;
      exp2   = '0;
   endtask

   initial begin
      void'($urandom(32'd1866));
      exp1 = '0;
      exp2 = '0;
      do_reset();
      // R3 R4: counting ramp, plain polarity
      for (int i = 0; i < 130; i++) step(6'(i), 1'b0);
      // R6: extreme codes with polarity high and low
      step(6'd0, 1'b1);  step(6'd63, 1'b1);
      step(6'd0, 1'b1);  step(6'd63, 1'b1);
      step(6'd63, 1'b1); step(6'd0, 1'b1);
      step(6'd0, 1'b0);  step(6'd63, 1'b0);
      step(6'd63, 1'b0); step(6'd0, 1'b0);
      // R7: polarity flips on non-update edges only
      for (int i = 0; i < 40; i++) step(6'($urandom), (edge_n % 2 == 1));
      // R5 R6 R7: random samples with random polarity
      for (int i = 0; i < 400; i++) step(6'($urandom), 1'($urandom));
      // R1 R8: reset in mid-stream, then refill
      do_reset();
      for (int i = 0; i < 60; i++) step(6'($urandom), 1'($urandom));
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule